// File: doc/BRIEF.md
# Serial Controller Command-Word Bridge

This block sits between a host and the byte-wide internal registers of a two-wire serial controller. It exposes a single 64-bit command word instead of a mapped register file. To launch an access, the host writes one word. That word carries a launch flag, an opcode, a register selector, a direction flag and a data byte.

The bridge decodes the stored word and issues one register strobe toward the serial engine. On a read, it folds the returned byte into the low byte of the same word. It then drops the launch flag. The host polls the word until the flag reads zero and only then uses the result.

While an access is in flight the word is locked: host writes are discarded, so a command cannot be corrupted halfway through. Each access takes a fixed two cycles from the accepting clock edge. This gives software and verification a deterministic handshake.

Top module: `serial_ctl_cmd_bridge`

## Requirements
- R1: After reset the command word reads all zeros and neither engine strobe is active.
- R2: A host write with bit 63 set, accepted while bit 63 of the stored word is clear, stores the word. Bit 63 then reads 1 for exactly two cycles after the accepting edge and reads 0 from the third.
- R3: With bits 59 and 58 both set, selector bits 34:32 pick the target. Selector 1 is data, 2 is control, 3 is clock-control (on write) or status (on read), and 7 is engine reset (write only). On a write, exactly one write strobe fires in the cycle after acceptance. During that cycle engSel equals the selector value and engWrByte equals word bits 7:0.
- R4: With bit 59 set and bit 58 clear, the clock-threshold register is addressed as engSel code 4, whatever the selector bits hold.
- R5: With bit 56 set, a read strobe fires instead of a write strobe, and the engine byte is captured into bits 7:0. All other bits, except bit 63, keep the value the host wrote.
- R6: Every other opcode or selector, and a read with selector 7 under the extended opcode, produces no strobe. Such an access still completes in two cycles, and a read of this kind returns 0x00 in bits 7:0.
- R7: A host write arriving while bit 63 reads 1 is ignored. The in-flight access and its result are unchanged, and no extra strobe follows.
- R8: A host write with bit 63 clear, made while idle, stores the word without issuing any strobe, and bit 63 stays 0.
- R9: A new command driven in the first cycle that bit 63 reads 0 is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write of the command word |
| hostWrData | input | 64 | Command word written by the host |
| hostRdData | output | 64 | Current command word, including the valid flag and read result |
| engSel | output | 3 | Internal register code: 1 data, 2 control, 3 clock-control/status, 4 threshold, 7 reset, 0 none |
| engWrStb | output | 1 | One-cycle internal register write strobe |
| engRdStb | output | 1 | One-cycle internal register read strobe |
| engWrByte | output | 8 | Byte written to the selected register |
| engRdByte | input | 8 | Byte returned by the selected register, sampled while engRdStb is high |

## Verification
The main sweep covers all four opcode combinations of bits 59:58, all eight selector values and both directions, each with a different data byte.

This sweep separates the extended decode from the plain threshold decode, and separate targets from the no-target cases. It also tells apart the read-capture path and the write-byte path. The engine model returns a byte that depends on engSel, so a wrong selector shows up in the captured result.

Directed sequences cover three more cases:
- a host write that keeps hammering the word through both busy cycles;
- an idle write without the launch flag;
- a command issued in the first idle cycle, which separates correct locking from an off-by-one in the busy window.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int WORD_W   = 64;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 3;
  localparam int VLD_BIT  = 63;
  localparam int OPX_HI   = 59;
  localparam int OPX_LO   = 58;
  localparam int RD_BIT   = 56;
  localparam int SEL_LSB  = 32;

  localparam logic [SEL_W-1:0] TGT_NONE  = 3'd0;
  localparam logic [SEL_W-1:0] TGT_DATA  = 3'd1;
  localparam logic [SEL_W-1:0] TGT_CTRL  = 3'd2;
  localparam logic [SEL_W-1:0] TGT_CLKST = 3'd3;
  localparam logic [SEL_W-1:0] TGT_THRSH = 3'd4;
  localparam logic [SEL_W-1:0] TGT_RESET = 3'd7;

  typedef struct packed {
    logic load;
    logic issue;
    logic finish;
  } strobe_t;

  typedef struct packed {
    logic             hit;
    logic [SEL_W-1:0] code;
  } target_t;

  function automatic target_t decodeWord(input logic [WORD_W-1:0] w);
    target_t t;
    logic [SEL_W-1:0] sel;
    sel = w[SEL_LSB +: SEL_W];
    t.hit  = 1'b0;
    t.code = TGT_NONE;
    if (w[OPX_HI] && w[OPX_LO]) begin
      case (sel)
        TGT_DATA, TGT_CTRL, TGT_CLKST: begin
          t.hit  = 1'b1;
          t.code = sel;
        end
        TGT_RESET: begin
          t.hit  = !w[RD_BIT];
          t.code = w[RD_BIT] ? TGT_NONE : TGT_RESET;
        end
        default: ;
      endcase
    end else if (w[OPX_HI]) begin
      t.hit  = 1'b1;
      t.code = TGT_THRSH;
    end
    return t;
  endfunction
endpackage

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostWrEn,
  input  logic    launchBit,
  output strobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_FINISH} phase_e;
  phase_e phase, phaseNext;

  always_comb begin
    stb.load   = hostWrEn && (phase == S_IDLE);
    stb.issue  = (phase == S_ISSUE);
    stb.finish = (phase == S_FINISH);
    phaseNext  = phase;
    case (phase)
      S_IDLE:   if (stb.load && launchBit) phaseNext = S_ISSUE;
      S_ISSUE:  phaseNext = S_FINISH;
      S_FINISH: phaseNext = S_IDLE;
      default:  phaseNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= S_IDLE;
    else       phase <= phaseNext;
  end
endmodule

// File: rtl/scb_datapath.sv
module scb_datapath
  import scb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] cmdWord,
  output logic [SEL_W-1:0]  engSel,
  output logic              engWrStb,
  output logic              engRdStb,
  output logic [BYTE_W-1:0] engWrByte,
  input  logic [BYTE_W-1:0] engRdByte
);
  target_t tgt;
  logic    isRead;

  always_comb begin
    tgt       = decodeWord(cmdWord);
    isRead    = cmdWord[RD_BIT];
    engSel    = tgt.code;
    engWrStb  = stb.issue && tgt.hit && !isRead;
    engRdStb  = stb.issue && tgt.hit && isRead;
    engWrByte = cmdWord[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord <= '0;
    end else if (stb.load) begin
      cmdWord <= hostWrData;
    end else begin
      if (stb.issue && isRead)
        cmdWord[BYTE_W-1:0] <= tgt.hit ? engRdByte : '0;
      if (stb.finish)
        cmdWord[VLD_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_ctl_cmd_bridge.sv
module serial_ctl_cmd_bridge
  import scb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [63:0] hostWrData,
  output logic [63:0] hostRdData,
  output logic [2:0]  engSel,
  output logic        engWrStb,
  output logic        engRdStb,
  output logic [7:0]  engWrByte,
  input  logic [7:0]  engRdByte
);
  strobe_t stb;

  scb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrEn  (hostWrEn),
    .launchBit (hostWrData[VLD_BIT]),
    .stb       (stb)
  );

  scb_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostWrData (hostWrData),
    .cmdWord    (hostRdData),
    .engSel     (engSel),
    .engWrStb   (engWrStb),
    .engRdStb   (engRdStb),
    .engWrByte  (engWrByte),
    .engRdByte  (engRdByte)
  );
endmodule

// File: rtl/scb_checker.sv
module scb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        hostWrEn,
  input logic [63:0] hostRdData,
  input logic        engWrStb,
  input logic        engRdStb
);
  p_valid_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostRdData[63]) |=> hostRdData[63]);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostRdData[63]) |-> ##2 !hostRdData[63]);
  p_strobe_in_flight_r3: assert property (@(posedge clk) disable iff (!rstN)
    (engWrStb || engRdStb) |-> hostRdData[63]);
  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (engWrStb || engRdStb) |=> !(engWrStb || engRdStb));
  p_dir_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(engWrStb && engRdStb));
  p_read_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    engRdStb |-> hostRdData[56]);
  p_busy_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostRdData[63]) |=> hostRdData[62:8] == $past(hostRdData[62:8]));
endmodule

bind serial_ctl_cmd_bridge scb_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostRdData (hostRdData),
  .engWrStb   (engWrStb),
  .engRdStb   (engRdStb)
);

// File: tb/test_serial_ctl_cmd_bridge.sv
module test_serial_ctl_cmd_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [63:0] hostWrData = '0;
  logic [63:0] hostRdData;
  logic [2:0]  engSel;
  logic        engWrStb, engRdStb;
  logic [7:0]  engWrByte, engRdByte;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] engModel(input logic [2:0] s);
    return 8'h30 + 8'(s) * 8'h11;
  endfunction
  assign engRdByte = engModel(engSel);

  serial_ctl_cmd_bridge i_serial_ctl_cmd_bridge (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .engSel(engSel), .engWrStb(engWrStb),
    .engRdStb(engRdStb), .engWrByte(engWrByte), .engRdByte(engRdByte)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkWord(input logic [1:0] op, input logic [2:0] sel,
                                         input logic rd, input logic [7:0] d, input logic vld);
    logic [63:0] w;
    w = 64'h2000_0A50_0000_0000;
    w[63] = vld;
    w[59:58] = op;
    w[56] = rd;
    w[34:32] = sel;
    w[7:0] = d;
    return w;
  endfunction

  // expected target from the requirements: hit flag and engine code
  task automatic expTarget(input logic [1:0] op, input logic [2:0] sel, input logic rd,
                           output logic hit, output logic [2:0] code);
    hit = 1'b0; code = 3'd0;
    if (op == 2'b11) begin
      if (sel == 3'd1 || sel == 3'd2 || sel == 3'd3) begin hit = 1'b1; code = sel; end
      else if (sel == 3'd7 && !rd) begin hit = 1'b1; code = 3'd7; end
    end else if (op == 2'b10) begin
      hit = 1'b1; code = 3'd4;
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [2:0] sel, input logic rd, input logic [7:0] d);
    logic hit;
    logic [2:0] code;
    logic [63:0] w, expW;
    string tag;
    expTarget(op, sel, rd, hit, code);
    tag = (op == 2'b10) ? "R4" : (!hit ? "R6" : (rd ? "R5" : "R3"));
    w = mkWord(op, sel, rd, d, 1'b1);
    expW = w;
    expW[63] = 1'b0;
    if (rd) expW[7:0] = hit ? engModel(code) : 8'h00;
    hostWrData = w; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    chk(hostRdData[63] == 1'b1, "R2 valid cycle1", {63'd0, hostRdData[63]}, 64'd1);
    chk(engWrStb == (hit && !rd), {tag, " wrStb"}, {63'd0, engWrStb}, {63'd0, hit && !rd});
    chk(engRdStb == (hit && rd), {tag, " rdStb"}, {63'd0, engRdStb}, {63'd0, hit && rd});
    if (hit) chk(engSel == code, {tag, " sel"}, {61'd0, engSel}, {61'd0, code});
    if (hit && !rd) chk(engWrByte == d, "R3 wrByte", {56'd0, engWrByte}, {56'd0, d});
    @(negedge clk);
    chk(hostRdData[63] == 1'b1, "R2 valid cycle2", {63'd0, hostRdData[63]}, 64'd1);
    chk(!engWrStb && !engRdStb, "R2 one strobe", {62'd0, engWrStb, engRdStb}, 64'd0);
    @(negedge clk);
    chk(hostRdData == expW, {tag, " result word"}, hostRdData, expW);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] wA, wB, expA;
    repeat (3) @(negedge clk);
    chk(hostRdData == 64'd0, "R1 word in reset", hostRdData, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(hostRdData == 64'd0, "R1 word after reset", hostRdData, 64'd0);
    chk(!engWrStb && !engRdStb, "R1 strobes", {62'd0, engWrStb, engRdStb}, 64'd0);

    // main sweep
    for (int op = 0; op < 4; op++)
      for (int sel = 0; sel < 8; sel++)
        for (int rd = 0; rd < 2; rd++)
          runOp(2'(op), 3'(sel), 1'(rd), 8'(8'h3C ^ (sel * 37 + op * 11 + rd * 5)));

    // R8: idle write without launch flag
    wA = mkWord(2'b11, 3'd2, 1'b0, 8'h9E, 1'b0);
    hostWrData = wA; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    chk(!engWrStb && !engRdStb, "R8 no strobe", {62'd0, engWrStb, engRdStb}, 64'd0);
    chk(hostRdData == wA, "R8 word stored", hostRdData, wA);
    @(negedge clk);
    chk(!engWrStb && !engRdStb, "R8 still none", {62'd0, engWrStb, engRdStb}, 64'd0);

    // R7: writes while busy are ignored
    wA = mkWord(2'b11, 3'd1, 1'b0, 8'hA7, 1'b1);
    wB = mkWord(2'b11, 3'd2, 1'b1, 8'h11, 1'b1);
    expA = wA; expA[63] = 1'b0;
    hostWrData = wA; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrData = wB;
    chk(engWrStb && engWrByte == 8'hA7, "R7 first access", {55'd0, engWrStb, engWrByte}, {55'd1, 8'hA7});
    @(negedge clk);
    chk(!engRdStb && !engWrStb, "R7 no second strobe", {62'd0, engWrStb, engRdStb}, 64'd0);
    @(negedge clk);
    hostWrEn = 1'b0;
    chk(hostRdData == expA, "R7 result kept", hostRdData, expA);
    @(negedge clk);
    chk(hostRdData == expA && !engRdStb && !engWrStb, "R7 nothing later", hostRdData, expA);

    // R9: back-to-back launch in first idle cycle
    wA = mkWord(2'b10, 3'd5, 1'b1, 8'h00, 1'b1);
    wB = mkWord(2'b11, 3'd3, 1'b0, 8'h5D, 1'b1);
    hostWrData = wA; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(hostRdData[63] == 1'b0 && hostRdData[7:0] == engModel(3'd4), "R9 first done",
        hostRdData, {1'b0, wA[62:8], engModel(3'd4)});
    hostWrData = wB; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    chk(hostRdData[63] && engWrStb && engSel == 3'd3 && engWrByte == 8'h5D, "R9 second accepted",
        {52'd0, hostRdData[63], engWrStb, engSel, engWrByte}, {52'd0, 1'b1, 1'b1, 3'd3, 8'h5D});
    @(negedge clk);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule